// File: doc/BRIEF.md
# Single-Parity-Check Leaf Decoder with Bit Flipping

This block decodes one single-parity-check constituent code inside a successive-cancellation style polar decoder that retries failed frames by flipping bits. It receives all node LLRs at once, makes hard decisions, and computes the parity over every position. Position 0 is the frozen parity position; positions 1 to NV-1 carry information bits. When the parity is odd, the decision of the least reliable position is inverted, so the returned word always satisfies the check.

Alongside the corrected word, the block produces one approximate reliability metric per information bit. A trial controller sorts these metrics across nodes to pick flip candidates. The metric is the position's magnitude, moved up or down by a scaled copy of the smallest magnitude in the node. On a later trial the controller sends a global information-bit index. If that index falls inside this node, two positions are inverted, chosen from the two least reliable positions, so that the parity still holds. One cycle separates an input strobe from the registered result.

Top module: `spc_flip_leaf`

## Requirements
- R1: With even parity and no flip request that hits the node, each bit of `bits_out` equals the sign bit of the matching LLR (1 for a negative LLR, 0 for zero or positive).
- R2: With odd parity, the decision of the position with the smallest magnitude is inverted, and every word on `bits_out` has even parity.
- R3: On magnitude ties, the smallest-magnitude position is the lowest tied index, and the second-smallest is the next lowest index that differs from it. Position 0 takes part in both searches.
- R4: With even parity, metric d (bits d*(LLR_W+1) upward in `dec_llr`) equals |LLR of position d+1| plus the scaled minimum magnitude.
- R5: With odd parity, metric d equals |LLR of position d+1| minus the scaled minimum magnitude, and is never negative.
- R6: SCALE selects the scale factor: the half setting uses the minimum magnitude shifted right by one bit (floor), and the full setting uses it unshifted.
- R7: A flip request whose index maps to the smallest-magnitude position inverts that position and the second-smallest position. Local position = flip_idx - base_idx + 1, for indices from base_idx to base_idx+NV-2.
- R8: A flip request that maps to any other position inverts that position and the smallest-magnitude position.
- R9: A flip request whose index lies outside the node's range, or with `flip_en` low, changes no bit of the result.
- R10: `out_valid` rises exactly one cycle after `in_valid`. `out_base` then carries the `base_idx` of that input. Without `in_valid`, `out_valid` is 0 and `bits_out`, `dec_llr` and `out_base` hold their values. After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input LLR vector and request are valid this cycle |
| llr_vec | input | NV*LLR_W | Signed two's-complement LLRs, position p in bits p*LLR_W upward |
| base_idx | input | IDX_W | Global index of this node's first information bit |
| flip_en | input | 1 | A flip request accompanies this input |
| flip_idx | input | IDX_W | Global information-bit index to flip |
| out_valid | output | 1 | Result registers were loaded on the last edge |
| bits_out | output | NV | Decoded word, position p in bit p |
| dec_llr | output | (NV-1)*(LLR_W+1) | Unsigned decision metrics, information bit d in field d |
| out_base | output | IDX_W | base_idx of the result, tagging metric d with global index out_base+d |

## Verification
The assertions assume that `base_idx + NV - 1` fits in IDX_W bits, so the node's index range never wraps. They also assume that `llr_vec` holds any two's-complement values, including the most negative code. The bench draws bases well below the top of the index range. It sweeps both full-range LLRs and LLRs from a narrow band around zero, which makes magnitude ties common. The flip indices it sends land on every local position, on the smallest-magnitude position, and just outside both ends of the range.

// File: rtl/spc_pkg.sv
package spc_pkg;
   localparam int MAX_NODE = 64;

   typedef enum logic {
      SCALE_FULL = 1'b0,
      SCALE_HALF = 1'b1
   } scale_e;
endpackage

// File: rtl/spc_sign_mag.sv
module spc_sign_mag #(
   parameter int LLR_W = 5
) (
   input  logic [LLR_W-1:0] llr_i,
   output logic             hd_o,
   output logic [LLR_W-1:0] mag_o
);
   always_comb begin
      hd_o  = llr_i[LLR_W-1];
      mag_o = hd_o ? (~llr_i + LLR_W'(1)) : llr_i;
   end
endmodule

// File: rtl/spc_two_min.sv
module spc_two_min #(
   parameter int NV    = 8,
   parameter int MAG_W = 5,
   localparam int POS_W = $clog2(NV)
) (
   input  logic [NV*MAG_W-1:0] mags_i,
   output logic [POS_W-1:0]    low1_o,
   output logic [POS_W-1:0]    low2_o,
   output logic [MAG_W-1:0]    min_o
);
   always_comb begin
      logic [MAG_W-1:0] m1, m2, cur;
      logic [POS_W-1:0] p1, p2;
      if (mags_i[MAG_W +: MAG_W] < mags_i[0 +: MAG_W]) begin
         m1 = mags_i[MAG_W +: MAG_W]; p1 = POS_W'(1);
         m2 = mags_i[0 +: MAG_W];     p2 = POS_W'(0);
      end else begin
         m1 = mags_i[0 +: MAG_W];     p1 = POS_W'(0);
         m2 = mags_i[MAG_W +: MAG_W]; p2 = POS_W'(1);
      end
      for (int i = 2; i < NV; i++) begin
         cur = mags_i[i*MAG_W +: MAG_W];
         if (cur < m1) begin
            m2 = m1; p2 = p1;
            m1 = cur; p1 = POS_W'(i);
         end else if (cur < m2) begin
            m2 = cur; p2 = POS_W'(i);
         end
      end
      low1_o = p1;
      low2_o = p2;
      min_o  = m1;
   end
endmodule

// File: rtl/spc_dec_metric.sv
module spc_dec_metric
   import spc_pkg::*;
#(
   parameter int     NV    = 8,
   parameter int     MAG_W = 5,
   parameter scale_e SCALE = SCALE_HALF,
   localparam int    DL_W  = MAG_W + 1,
   localparam int    NINFO = NV - 1
) (
   input  logic [NINFO*MAG_W-1:0] info_mags_i,
   input  logic [MAG_W-1:0]       min_i,
   input  logic                   odd_i,
   output logic [NINFO*DL_W-1:0]  metric_o
);
   logic [MAG_W-1:0] offset;

   if (SCALE == SCALE_HALF) begin : g_half
      assign offset = min_i >> 1;
   end else begin : g_full
      assign offset = min_i;
   end

   for (genvar d = 0; d < NINFO; d++) begin : g_bit
      logic signed [DL_W:0] sum;
      always_comb begin
         if (odd_i)
            sum = $signed({2'b00, info_mags_i[d*MAG_W +: MAG_W]}) - $signed({2'b00, offset});
         else
            sum = $signed({2'b00, info_mags_i[d*MAG_W +: MAG_W]}) + $signed({2'b00, offset});
         metric_o[d*DL_W +: DL_W] = sum[DL_W] ? '0 : sum[DL_W-1:0];
      end
   end
endmodule

// File: rtl/spc_flip_leaf.sv
module spc_flip_leaf
   import spc_pkg::*;
#(
   parameter int     NV    = 8,
   parameter int     LLR_W = 5,
   parameter int     IDX_W = 10,
   parameter scale_e SCALE = SCALE_HALF,
   localparam int    POS_W = $clog2(NV),
   localparam int    MAG_W = LLR_W,
   localparam int    DL_W  = LLR_W + 1,
   localparam int    NINFO = NV - 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  in_valid,
   input  logic [NV*LLR_W-1:0]   llr_vec,
   input  logic [IDX_W-1:0]      base_idx,
   input  logic                  flip_en,
   input  logic [IDX_W-1:0]      flip_idx,
   output logic                  out_valid,
   output logic [NV-1:0]         bits_out,
   output logic [NINFO*DL_W-1:0] dec_llr,
   output logic [IDX_W-1:0]      out_base
);
   if (NV < 2 || NV > MAX_NODE) begin : g_bad_nv
      $error("spc_flip_leaf: NV out of range");
   end
   if (LLR_W < 2) begin : g_bad_w
      $error("spc_flip_leaf: LLR_W too small");
   end
   if ((1 << IDX_W) <= NV) begin : g_bad_idx
      $error("spc_flip_leaf: IDX_W too small for NV");
   end

   localparam logic [IDX_W-1:0] NINFO_I = IDX_W'(NINFO);
   localparam logic [NV-1:0]    ONE_V   = NV'(1);

   logic [NV-1:0]         hd_raw;
   logic [NV*MAG_W-1:0]   mag_flat;
   logic [POS_W-1:0]      low1, low2;
   logic [MAG_W-1:0]      min_mag;
   logic                  odd;
   logic [NINFO*DL_W-1:0] metric;

   for (genvar g = 0; g < NV; g++) begin : g_pos
      spc_sign_mag #(.LLR_W(LLR_W)) u_sm (
         .llr_i (llr_vec[g*LLR_W +: LLR_W]),
         .hd_o  (hd_raw[g]),
         .mag_o (mag_flat[g*MAG_W +: MAG_W])
      );
   end

   assign odd = ^hd_raw;

   spc_two_min #(.NV(NV), .MAG_W(MAG_W)) u_min (
      .mags_i (mag_flat),
      .low1_o (low1),
      .low2_o (low2),
      .min_o  (min_mag)
   );

   spc_dec_metric #(.NV(NV), .MAG_W(MAG_W), .SCALE(SCALE)) u_metric (
      .info_mags_i (mag_flat[NV*MAG_W-1:MAG_W]),
      .min_i       (min_mag),
      .odd_i       (odd),
      .metric_o    (metric)
   );

   // Flip request: map global index to a local position (skip frozen 0).
   logic [IDX_W:0]   offs;
   logic             flip_hit;
   logic [POS_W-1:0] flip_pos, partner;
   logic [NV-1:0]    fixed_bits, next_bits;

   always_comb begin
      offs     = {1'b0, flip_idx} - {1'b0, base_idx};
      flip_hit = flip_en && !offs[IDX_W] && (offs[IDX_W-1:0] < NINFO_I);
      flip_pos = offs[POS_W-1:0] + POS_W'(1);
      partner  = (flip_pos == low1) ? low2 : low1;
      fixed_bits = hd_raw ^ (odd ? (ONE_V << low1) : '0);
      next_bits  = fixed_bits;
      if (flip_hit)
         next_bits = fixed_bits ^ (ONE_V << flip_pos) ^ (ONE_V << partner);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         bits_out  <= '0;
         dec_llr   <= '0;
         out_base  <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            bits_out <= next_bits;
            dec_llr  <= metric;
            out_base <= base_idx;
         end
      end
   end

   // R2
   parity_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (^bits_out == 1'b0));

   // R3
   min_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (low1 != low2));

   // R3
   min_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |-> (mag_flat[low1*MAG_W +: MAG_W] <= mag_flat[low2*MAG_W +: MAG_W]));

   // R10
   valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(bits_out) && $stable(dec_llr) && $stable(out_base)));
endmodule

// File: tb/spc_flip_leaf_tb.sv
module spc_flip_leaf_tb_top;
   import spc_pkg::*;

   localparam int NV    = 8;
   localparam int LLR_W = 5;
   localparam int IDX_W = 10;
   localparam int DL_W  = LLR_W + 1;
   localparam int NINFO = NV - 1;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  in_valid = 1'b0;
   logic [NV*LLR_W-1:0]   llr_vec = '0;
   logic [IDX_W-1:0]      base_idx = '0;
   logic                  flip_en = 1'b0;
   logic [IDX_W-1:0]      flip_idx = '0;
   logic                  out_valid, out_valid_f;
   logic [NV-1:0]         bits_out, bits_out_f;
   logic [NINFO*DL_W-1:0] dec_llr, dec_llr_f;
   logic [IDX_W-1:0]      out_base, out_base_f;

   always #5 clk = ~clk;

   spc_flip_leaf #(.NV(NV), .LLR_W(LLR_W), .IDX_W(IDX_W), .SCALE(SCALE_HALF)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .llr_vec(llr_vec),
      .base_idx(base_idx), .flip_en(flip_en), .flip_idx(flip_idx),
      .out_valid(out_valid), .bits_out(bits_out), .dec_llr(dec_llr), .out_base(out_base));

   spc_flip_leaf #(.NV(NV), .LLR_W(LLR_W), .IDX_W(IDX_W), .SCALE(SCALE_FULL)) dut_full_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .llr_vec(llr_vec),
      .base_idx(base_idx), .flip_en(flip_en), .flip_idx(flip_idx),
      .out_valid(out_valid_f), .bits_out(bits_out_f), .dec_llr(dec_llr_f), .out_base(out_base_f));

   int total = 0;
   int bad = 0;
   int vals [NV];
   int m_i1, m_i2, m_min, m_par;
   logic [NV-1:0] m_bits;
   logic [31:0] rnd = 32'h1234_5678;

   function automatic int mag_of(int v);
      return (v < 0) ? -v : v;
   endfunction

   task automatic next_rnd();
      rnd = rnd ^ (rnd << 13);
      rnd = rnd ^ (rnd >> 17);
      rnd = rnd ^ (rnd << 5);
   endtask

   task automatic check(string tag, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Reference minimum search per R3: lowest index wins ties.
   task automatic model_min();
      m_i1 = 0; m_min = mag_of(vals[0]);
      for (int p = 1; p < NV; p++)
         if (mag_of(vals[p]) < m_min) begin m_min = mag_of(vals[p]); m_i1 = p; end
      m_i2 = -1;
      for (int p = 0; p < NV; p++)
         if (p != m_i1 && (m_i2 < 0 || mag_of(vals[p]) < mag_of(vals[m_i2]))) m_i2 = p;
      m_par = 0;
      for (int p = 0; p < NV; p++) if (vals[p] < 0) m_par ^= 1;
   endtask

   task automatic run_vec(int base, bit fen, int fidx, string tie_tag);
      int offs, loc, partner;
      bit hit;
      string tag;
      model_min();
      m_bits = '0;
      for (int p = 0; p < NV; p++) m_bits[p] = (vals[p] < 0);
      if (m_par == 1) m_bits[m_i1] = ~m_bits[m_i1];
      offs = fidx - base;
      hit  = fen && offs >= 0 && offs < NINFO;
      tag  = (m_par == 1) ? "R2" : "R1";
      if (fen && !hit) tag = "R9";
      if (hit) begin
         loc = offs + 1;
         partner = (loc == m_i1) ? m_i2 : m_i1;
         tag = (loc == m_i1) ? "R7" : "R8";
         m_bits[loc] = ~m_bits[loc];
         m_bits[partner] = ~m_bits[partner];
      end
      if (tie_tag != "") tag = tie_tag;

      @(negedge clk);
      for (int p = 0; p < NV; p++) llr_vec[p*LLR_W +: LLR_W] = LLR_W'(vals[p]);
      base_idx = IDX_W'(base);
      flip_en  = fen;
      flip_idx = IDX_W'(fidx);
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;

      check("R10 out_valid", int'(out_valid), 1);
      check({tag, " bits_out"}, int'(bits_out), int'(m_bits));
      check({tag, " bits_out full"}, int'(bits_out_f), int'(m_bits));
      check("R10 out_base", int'(out_base), base);
      for (int d = 0; d < NINFO; d++) begin
         int eh, ef;
         eh = (m_par == 1) ? mag_of(vals[d+1]) - (m_min >> 1) : mag_of(vals[d+1]) + (m_min >> 1);
         ef = (m_par == 1) ? mag_of(vals[d+1]) - m_min : mag_of(vals[d+1]) + m_min;
         if (eh < 0) eh = 0;
         if (ef < 0) ef = 0;
         check((m_par == 1) ? "R5 metric half" : "R4 metric half",
               int'(dec_llr[d*DL_W +: DL_W]), eh);
         check("R6 metric full", int'(dec_llr_f[d*DL_W +: DL_W]), ef);
      end
   endtask

   initial begin
      #(200000 * 10);
      bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic [NV-1:0] held;
      repeat (3) @(negedge clk);
      // R10 reset state
      check("R10 reset out_valid", int'(out_valid), 0);
      check("R10 reset bits_out", int'(bits_out), 0);
      check("R10 reset dec_llr", int'(dec_llr), 0);
      check("R10 reset out_base", int'(out_base), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R3: all magnitudes equal, odd parity -> position 0 corrected.
      vals = '{3, 3, -3, 3, 3, 3, 3, 3};
      run_vec(20, 1'b0, 0, "R3");
      // R3 with R8: flip local position 1 pairs with position 0.
      run_vec(20, 1'b1, 20, "R3");
      // R3 with R7: min at 1, tie for second at 2 and 3.
      vals = '{5, 1, 2, -2, 6, 7, 4, 4};
      run_vec(40, 1'b1, 40, "R3");
      // Most negative code.
      vals = '{-16, -16, 15, 0, -1, 9, 0, 12};
      run_vec(100, 1'b1, 102, "");

      // Sweep.
      for (int it = 0; it < 4000; it++) begin
         int base, fidx, sel;
         bit fen;
         for (int p = 0; p < NV; p++) begin
            next_rnd();
            vals[p] = ((it % 4) == 0) ? int'(rnd % 5) - 2 : int'(rnd % 32) - 16;
         end
         next_rnd();
         base = int'(rnd % 900);
         sel  = it % 11;
         fen  = 1'b1;
         fidx = base + sel;
         if (sel == 7) fen = 1'b0;
         else if (sel == 8) fidx = base + NINFO;
         else if (sel == 9) fidx = (base > 0) ? base - 1 : base + NV + 3;
         else if (sel == 10) begin
            model_min();
            fidx = (m_i1 > 0) ? base + m_i1 - 1 : base + 2;
         end
         run_vec(base, fen, fidx, "");

         if ((it % 50) == 0) begin
            // R10: inputs change without a strobe; outputs hold.
            held = bits_out;
            @(negedge clk);
            llr_vec = ~llr_vec;
            base_idx = base_idx + 1;
            @(negedge clk);
            check("R10 hold out_valid", int'(out_valid), 0);
            check("R10 hold bits_out", int'(bits_out), int'(held));
            check("R10 hold out_base", int'(out_base), base);
         end
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule